// File: doc/BRIEF.md
# Serial Centroid Averaging Divider

This block produces the updated centroid coordinates at the end of one clustering pass. For every cluster it takes the accumulated coordinate sum and the number of member samples, and it divides the sum by the count. The sums and the previous centroids are signed fixed-point words with `FRAC_W` fractional bits. The counts are plain non-negative integers. One radix-2 non-restoring divider is shared by every cluster and every dimension, so the divisions run one after another. All clusters are done for the first dimension (x) before any cluster is done for the second (y).

A single `start` pulse captures the whole operand set into internal registers. The caller can then change its inputs freely. While the pass runs, `busy` stays high. For each element the block raises `res_valid` for one cycle, together with the quotient and the cluster and dimension it belongs to. A cluster with a count of zero is not divided: it returns its previous centroid. `batch_done` marks the last result of a pass.

Inside the divider the dividend is shifted left by `FRAC_W` bits. The integer count is placed in the same fixed-point grid, so the quotient keeps the input format. The sign of a negative sum is removed before the division and put back on the quotient.

Top module: `centroid_avg_div`

## Requirements
- R1: After synchronous reset, `busy`, `res_valid` and `batch_done` are low and `res_data` is zero.
- R2: `start` is accepted only while `busy` is low. The operands are captured on that edge and `busy` is high from the next cycle. A `start` seen while `busy` is high has no effect, and neither do input changes after capture.
- R3: Results come out in a fixed order: element index = dim*NUM_CL + cluster, ascending. That is clusters 0..NUM_CL-1 of dimension 0 (x) first, then the same clusters of dimension 1 (y). `res_cluster` and `res_dim` name the element.
- R4: For a non-zero count, `res_data` is the signed sum divided by the count, rounded toward zero, in the same fixed-point format as the sum.
- R5: A division occupies the shared divider for 30 cycles from its issue to its result register. The first divided result appears 31 cycles after the accepting `start` edge. Each later divided result appears 31 cycles after the previous result.
- R6: For a zero count, `res_data` is that element's previous centroid. The result appears 1 cycle after the element's turn begins, and the divider is not started.
- R7: Every pass yields exactly NUM_CL*NUM_DIM one-cycle `res_valid` pulses. `batch_done` is high only together with the last of them, in the same cycle in which `busy` falls. `res_data` holds its value between pulses.
- R8: At most one division is in flight at any time.
- R9: Extreme operands are exact: the most negative sum with count 1 returns itself, and the largest count divides correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass; captures all operands |
| sum_flat | input | NUM_CL*NUM_DIM*DATA_W | Signed sums, element e at bits [e*DATA_W +: DATA_W] |
| count_flat | input | NUM_CL*CNT_W | Cluster sizes, cluster k at bits [k*CNT_W +: CNT_W] |
| prev_flat | input | NUM_CL*NUM_DIM*DATA_W | Previous centroids, same layout as sums |
| busy | output | 1 | Pass in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | New centroid coordinate |
| res_cluster | output | CL_W | Cluster index of the result |
| res_dim | output | DIM_W | Dimension of the result (0 = x) |
| batch_done | output | 1 | Last result of the pass |

## Verification
Two functions can fall on the same clock edge: retiring the last result of a pass, and accepting a new `start`. The bench holds `start` high across a whole pass. On the edge that emits `batch_done`, that request must still be refused. It must be accepted on the very next edge. The scoreboard checks this through the timing of every result of the second pass, which shifts by one cycle if the request were taken early or late. The same run changes the inputs mid-pass to show that the captured operands of the first pass are unaffected.

// File: rtl/cavg_pkg.sv
package cavg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_FIX  = 2'd2
  } div_phase_t;

endpackage

// File: rtl/cavg_nr_divider.sv
// Radix-2 non-restoring divider, one quotient bit per cycle.
// Magnitude division with sign restored on the quotient.
module cavg_nr_divider
  import cavg_pkg::*;
#(
  parameter int DVD_W = 18,
  parameter int DVS_W = 4,
  parameter int SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int ITER   = DVD_W + SHIFT;
  localparam int DEN_W  = DVS_W + SHIFT;
  localparam int RW     = DEN_W + 2;
  localparam int STEP_W = $clog2(ITER + 1);

  div_phase_t             phase;
  logic signed [RW-1:0]   rem;
  logic [ITER-1:0]        quo;
  logic [DEN_W-1:0]       den;
  logic                   neg;
  logic [STEP_W-1:0]      step;

  logic [DVD_W-1:0]       mag;
  logic signed [RW-1:0]   den_ext;
  logic signed [RW-1:0]   rem_sh;
  logic signed [RW-1:0]   rem_nx;
  logic [ITER-1:0]        quo_nx;

  always_comb begin
    mag     = dividend_i[DVD_W-1] ? (~dividend_i + 1'b1) : dividend_i;
    den_ext = $signed({2'b00, den});
    rem_sh  = {rem[RW-2:0], quo[ITER-1]};
    rem_nx  = rem[RW-1] ? (rem_sh + den_ext) : (rem_sh - den_ext);
    quo_nx  = {quo[ITER-2:0], ~rem_nx[RW-1]};
  end

  assign busy_o = (phase != DIV_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= DIV_IDLE;
      rem    <= '0;
      quo    <= '0;
      den    <= '0;
      neg    <= 1'b0;
      step   <= '0;
      done_o <= 1'b0;
      quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        DIV_IDLE: begin
          if (start_i) begin
            phase <= DIV_RUN;
            rem   <= '0;
            quo   <= {mag, {SHIFT{1'b0}}};
            den   <= {divisor_i, {SHIFT{1'b0}}};
            neg   <= dividend_i[DVD_W-1];
            step  <= STEP_W'(ITER);
          end
        end
        DIV_RUN: begin
          rem  <= rem_nx;
          quo  <= quo_nx;
          step <= step - STEP_W'(1);
          if (step == STEP_W'(1)) phase <= DIV_FIX;
        end
        DIV_FIX: begin
          if (rem[RW-1]) rem <= rem + den_ext;
          quot_o <= neg ? (~quo[DVD_W-1:0] + 1'b1) : quo[DVD_W-1:0];
          done_o <= 1'b1;
          phase  <= DIV_IDLE;
        end
        default: phase <= DIV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cavg_operand_mux.sv
// Selects the captured operands of the element now being processed.
module cavg_operand_mux #(
  parameter int NUM_CL  = 3,
  parameter int NUM_DIM = 2,
  parameter int DATA_W  = 18,
  parameter int CNT_W   = 4,
  parameter int CL_W    = 2,
  parameter int DIM_W   = 1
) (
  input  logic [NUM_CL*NUM_DIM*DATA_W-1:0] sum_q,
  input  logic [NUM_CL*CNT_W-1:0]          cnt_q,
  input  logic [NUM_CL*NUM_DIM*DATA_W-1:0] prev_q,
  input  logic [CL_W-1:0]                  cluster,
  input  logic [DIM_W-1:0]                 dim,
  output logic [DATA_W-1:0]                sum_sel,
  output logic [DATA_W-1:0]                prev_sel,
  output logic [CNT_W-1:0]                 cnt_sel
);
  localparam int NUM_EL = NUM_CL * NUM_DIM;

  logic [DATA_W-1:0] sum_arr  [NUM_EL];
  logic [DATA_W-1:0] prev_arr [NUM_EL];
  logic [CNT_W-1:0]  cnt_arr  [NUM_CL];

  for (genvar e = 0; e < NUM_EL; e++) begin : g_el
    assign sum_arr[e]  = sum_q[e*DATA_W +: DATA_W];
    assign prev_arr[e] = prev_q[e*DATA_W +: DATA_W];
  end
  for (genvar k = 0; k < NUM_CL; k++) begin : g_cl
    assign cnt_arr[k] = cnt_q[k*CNT_W +: CNT_W];
  end

  int el_idx;
  always_comb begin
    el_idx   = int'(dim) * NUM_CL + int'(cluster);
    sum_sel  = '0;
    prev_sel = '0;
    cnt_sel  = '0;
    if (el_idx < NUM_EL) begin
      sum_sel  = sum_arr[el_idx];
      prev_sel = prev_arr[el_idx];
    end
    if (int'(cluster) < NUM_CL) cnt_sel = cnt_arr[cluster];
  end

endmodule

// File: rtl/cavg_sequencer.sv
// Walks the elements: all clusters of dim 0, then dim 1, ...
module cavg_sequencer
  import cavg_pkg::*;
#(
  parameter int NUM_CL  = 3,
  parameter int NUM_DIM = 2,
  parameter int CL_W    = 2,
  parameter int DIM_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cnt_zero_i,
  input  logic             div_done_i,
  output logic             busy_o,
  output logic             capture_o,
  output logic             issue_o,
  output logic             take_div_o,
  output logic             skip_o,
  output logic             last_o,
  output logic [CL_W-1:0]  cluster_o,
  output logic [DIM_W-1:0] dim_o
);
  seq_state_t state;
  logic       advance;

  always_comb begin
    capture_o  = (state == SEQ_IDLE) && start_i;
    skip_o     = (state == SEQ_ISSUE) && cnt_zero_i;
    issue_o    = (state == SEQ_ISSUE) && !cnt_zero_i;
    take_div_o = (state == SEQ_WAIT) && div_done_i;
    advance    = skip_o || take_div_o;
    last_o     = (cluster_o == CL_W'(NUM_CL - 1)) && (dim_o == DIM_W'(NUM_DIM - 1));
    busy_o     = (state != SEQ_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      cluster_o <= '0;
      dim_o     <= '0;
    end else begin
      if (capture_o) begin
        state     <= SEQ_ISSUE;
        cluster_o <= '0;
        dim_o     <= '0;
      end else if (issue_o) begin
        state <= SEQ_WAIT;
      end else if (advance) begin
        if (last_o) begin
          state <= SEQ_IDLE;
        end else begin
          state <= SEQ_ISSUE;
          if (cluster_o == CL_W'(NUM_CL - 1)) begin
            cluster_o <= '0;
            dim_o     <= dim_o + DIM_W'(1);
          end else begin
            cluster_o <= cluster_o + CL_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/centroid_avg_div.sv
module centroid_avg_div #(
  parameter int NUM_CL  = 3,
  parameter int NUM_DIM = 2,
  parameter int DATA_W  = 18,
  parameter int FRAC_W  = 10,
  parameter int CNT_W   = 4,
  localparam int NUM_EL = NUM_CL * NUM_DIM,
  localparam int CL_W   = (NUM_CL > 1) ? $clog2(NUM_CL) : 1,
  localparam int DIM_W  = (NUM_DIM > 1) ? $clog2(NUM_DIM) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NUM_EL*DATA_W-1:0] sum_flat,
  input  logic [NUM_CL*CNT_W-1:0]  count_flat,
  input  logic [NUM_EL*DATA_W-1:0] prev_flat,
  output logic                     busy,
  output logic                     res_valid,
  output logic [DATA_W-1:0]        res_data,
  output logic [CL_W-1:0]          res_cluster,
  output logic [DIM_W-1:0]         res_dim,
  output logic                     batch_done
);
  logic [NUM_EL*DATA_W-1:0] sum_q;
  logic [NUM_CL*CNT_W-1:0]  cnt_q;
  logic [NUM_EL*DATA_W-1:0] prev_q;

  logic              capture, div_start, take_div, skip, last;
  logic [CL_W-1:0]   cluster;
  logic [DIM_W-1:0]  dim;
  logic [DATA_W-1:0] sum_sel, prev_sel, div_quot;
  logic [CNT_W-1:0]  cnt_sel;
  logic              div_busy, div_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (capture) begin
      sum_q  <= sum_flat;
      cnt_q  <= count_flat;
      prev_q <= prev_flat;
    end
  end

  cavg_sequencer #(
    .NUM_CL(NUM_CL), .NUM_DIM(NUM_DIM), .CL_W(CL_W), .DIM_W(DIM_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .cnt_zero_i (cnt_sel == '0),
    .div_done_i (div_done),
    .busy_o     (busy),
    .capture_o  (capture),
    .issue_o    (div_start),
    .take_div_o (take_div),
    .skip_o     (skip),
    .last_o     (last),
    .cluster_o  (cluster),
    .dim_o      (dim)
  );

  cavg_operand_mux #(
    .NUM_CL(NUM_CL), .NUM_DIM(NUM_DIM), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CL_W(CL_W), .DIM_W(DIM_W)
  ) u_mux (
    .sum_q    (sum_q),
    .cnt_q    (cnt_q),
    .prev_q   (prev_q),
    .cluster  (cluster),
    .dim      (dim),
    .sum_sel  (sum_sel),
    .prev_sel (prev_sel),
    .cnt_sel  (cnt_sel)
  );

  cavg_nr_divider #(
    .DVD_W(DATA_W), .DVS_W(CNT_W), .SHIFT(FRAC_W)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .start_i    (div_start),
    .dividend_i (sum_sel),
    .divisor_i  (cnt_sel),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_cluster <= '0;
      res_dim     <= '0;
      batch_done  <= 1'b0;
    end else begin
      res_valid  <= take_div || skip;
      batch_done <= (take_div || skip) && last;
      if (take_div || skip) begin
        res_data    <= skip ? prev_sel : div_quot;
        res_cluster <= cluster;
        res_dim     <= dim;
      end
    end
  end

endmodule

// File: rtl/cavg_checker.sv
module cavg_checker #(
  parameter int NUM_CL  = 3,
  parameter int NUM_DIM = 2,
  parameter int DATA_W  = 18,
  parameter int CNT_W   = 4,
  parameter int CL_W    = 2,
  parameter int DIM_W   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic [CL_W-1:0]   res_cluster,
  input logic [DIM_W-1:0]  res_dim,
  input logic              batch_done,
  input logic              div_start,
  input logic              div_busy,
  input logic [CNT_W-1:0]  cnt_sel
);
  // R8
  one_divider_chk: assert property (@(posedge clk) disable iff (rst)
    div_start |-> !div_busy);

  // R6
  zero_not_divided_chk: assert property (@(posedge clk) disable iff (rst)
    div_start |-> (cnt_sel != '0));

  // R7
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    batch_done |-> (res_valid && !busy &&
                    res_cluster == CL_W'(NUM_CL - 1) &&
                    res_dim == DIM_W'(NUM_DIM - 1)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7
  valid_in_pass_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(busy));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_data));

endmodule

bind centroid_avg_div cavg_checker #(
  .NUM_CL(NUM_CL), .NUM_DIM(NUM_DIM), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .CL_W(CL_W), .DIM_W(DIM_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_data    (res_data),
  .res_cluster (res_cluster),
  .res_dim     (res_dim),
  .batch_done  (batch_done),
  .div_start   (div_start),
  .div_busy    (div_busy),
  .cnt_sel     (cnt_sel)
);

// File: tb/test_centroid_avg_div.sv
module test_centroid_avg_div;
  localparam int K  = 3;
  localparam int D  = 2;
  localparam int DW = 18;
  localparam int CW = 4;
  localparam int NE = K * D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NE*DW-1:0] sum_flat = '0;
  logic [K*CW-1:0]  count_flat = '0;
  logic [NE*DW-1:0] prev_flat = '0;
  logic busy, res_valid, batch_done;
  logic [DW-1:0] res_data;
  logic [1:0] res_cluster;
  logic [0:0] res_dim;

  always #10 clk = ~clk;

  centroid_avg_div i_centroid_avg_div (
    .clk(clk), .rst(rst), .start(start), .sum_flat(sum_flat),
    .count_flat(count_flat), .prev_flat(prev_flat), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_cluster(res_cluster),
    .res_dim(res_dim), .batch_done(batch_done)
  );

  typedef struct {
    int    data;
    int    cl;
    int    dm;
    int    t;
    bit    last;
    string vreq;
    string treq;
  } exp_t;

  exp_t q_exp[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int s_arr[NE];
  int c_arr[K];
  int p_arr[NE];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_ops();
    for (int i = 0; i < NE; i++) begin
      sum_flat[i*DW +: DW]  = DW'(s_arr[i]);
      prev_flat[i*DW +: DW] = DW'(p_arr[i]);
    end
    for (int k = 0; k < K; k++) count_flat[k*CW +: CW] = CW'(c_arr[k]);
  endtask

  // Driver side of the scoreboard: expected results with their edge numbers.
  task automatic push_expected(int s_edge, string vtag, output int last_t);
    int e;
    e = s_edge + 1;
    for (int i = 0; i < NE; i++) begin
      exp_t it;
      it.cl = i % K;
      it.dm = i / K;
      it.last = (i == NE - 1);
      if (c_arr[it.cl] != 0) begin
        it.data = s_arr[i] / c_arr[it.cl];
        it.t = e + 30;
        e = it.t + 1;
        it.vreq = vtag;
        it.treq = "R5";
      end else begin
        it.data = p_arr[i];
        it.t = e;
        e = e + 1;
        it.vreq = "R6";
        it.treq = "R6";
      end
      last_t = it.t;
      q_exp.push_back(it);
    end
  endtask

  task automatic wait_drain();
    while (q_exp.size() != 0) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R7", "busy after pass", int'(busy), 0);
  endtask

  task automatic run_batch(string vtag, bit poke);
    int s_edge, last_t;
    @(negedge clk);
    apply_ops();
    start = 1'b1;
    @(posedge clk);
    #1;
    s_edge = cyc;
    start = 1'b0;
    push_expected(s_edge, vtag, last_t);
    if (poke) begin
      // R2: new operands and a start pulse mid-pass must change nothing
      repeat (10) @(negedge clk);
      for (int i = 0; i < NE; i++) s_arr[i] = 1000 + i;
      for (int k = 0; k < K; k++) c_arr[k] = 1;
      apply_ops();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_drain();
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (q_exp.size() == 0) begin
          chk(1'b0, "R7", "unexpected result", 1, 0);
        end else begin
          exp_t it;
          it = q_exp.pop_front();
          chk(int'($signed(res_data)) == it.data, it.vreq, "result value",
              int'($signed(res_data)), it.data);
          chk(int'(res_cluster) == it.cl && int'(res_dim) == it.dm, "R3",
              "element order", int'(res_dim) * K + int'(res_cluster),
              it.dm * K + it.cl);
          chk(cyc == it.t, it.treq, "result cycle", cyc, it.t);
          chk(batch_done == it.last, "R7", "batch_done flag",
              int'(batch_done), int'(it.last));
        end
      end else if (batch_done) begin
        chk(1'b0, "R7", "batch_done without result", 1, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual %0d expected 0 pending", q_exp.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s_edge, l1, l2;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);
    chk(batch_done == 1'b0, "R1", "batch_done after reset", int'(batch_done), 0);
    chk(res_data == '0, "R1", "res_data after reset", int'(res_data), 0);

    // R4: positive sums, exact and fractional quotients
    s_arr = '{3584, 2048, 5 * 1024 + 300, 6144, 1025, 10240};
    c_arr = '{3, 2, 5};
    p_arr = '{0, 0, 0, 0, 0, 0};
    run_batch("R4", 1'b0);

    // R4: negative sums truncate toward zero
    s_arr = '{-7, -3072, -5, -100000, -1, 77777};
    c_arr = '{2, 7, 4};
    p_arr = '{0, 0, 0, 0, 0, 0};
    run_batch("R4", 1'b0);

    // R6: one empty cluster keeps its previous centroid
    s_arr = '{4096, 999, -2048, 512, 888, 300};
    c_arr = '{4, 0, 3};
    p_arr = '{11, -2222, 33, 44, 5555, 66};
    run_batch("R4", 1'b0);

    // R6: every cluster empty, one result per cycle
    s_arr = '{1, 2, 3, 4, 5, 6};
    c_arr = '{0, 0, 0};
    p_arr = '{-131072, 131071, 0, -1, 1024, -1024};
    run_batch("R6", 1'b0);

    // R9: extremes of sum and count
    s_arr = '{-131072, 131071, -131072, 131071, -1, 15};
    c_arr = '{1, 15, 15};
    p_arr = '{0, 0, 0, 0, 0, 0};
    run_batch("R9", 1'b0);

    // R2: start and input changes mid-pass are ignored
    s_arr = '{2000, -4000, 6000, -8000, 10000, -12000};
    c_arr = '{2, 0, 6};
    p_arr = '{7, 8, 9, 10, 11, 12};
    run_batch("R2", 1'b1);

    // R2: start held high; refused on the batch_done edge, taken the next
    s_arr = '{300, 600, 900, 1200, 1500, 1800};
    c_arr = '{3, 6, 9};
    p_arr = '{0, 0, 0, 0, 0, 0};
    @(negedge clk);
    apply_ops();
    start = 1'b1;
    @(posedge clk);
    #1;
    s_edge = cyc;
    push_expected(s_edge, "R4", l1);
    s_arr = '{-900, 450, 0, 30000, -30000, 7};
    c_arr = '{0, 5, 1};
    p_arr = '{321, 0, 0, -654, 0, 0};
    apply_ops();
    push_expected(l1 + 1, "R2", l2);
    while (cyc < l1 + 1) @(posedge clk);
    #1 start = 1'b0;
    wait_drain();

    chk(q_exp.size() == 0, "R7", "pending results", q_exp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule